// File: doc/BRIEF.md
# Synonym-Safe Virtual Cache with Unaligned-Line Pointers

This block is a direct-mapped cache that is indexed and tagged by virtual address. The same physical block can be reached through more than one virtual alias, and the cache still never holds two live copies of it. It does this without keeping a reverse map for every line. A line index is split into an in-page part and a "colour" part. The colour is the low bits of the page number that also select the line.

An access whose virtual colour equals its physical colour is aligned. Any aligned copy of a physical block can only sit at the line named by the physical address itself, so it can be found directly. Only lines filled through unaligned accesses get a reverse pointer. These pointers are held in a small direct-mapped pointer store keyed by physical address. That store may have a single entry and the cache still stays coherent. The price of a small store is extra evictions.

Each request carries:
- the virtual address,
- the already-translated physical address,
- a write flag,
- write data.

A hit completes in two cycles after acceptance. A miss checks the pointer store and the physically indexed line, then runs the needed write-backs and at most one memory read, then installs the line. Every response carries a two-bit code that tells which kind of miss handling took place.

Top module: `syn_vcache`

## Requirements
- R1: An access is aligned exactly when virtual address bits [IDX_W-1:PAGE_W] equal physical address bits [IDX_W-1:PAGE_W]. The line index is virtual bits [IDX_W-1:0]. The virtual tag is virtual bits [VA_W-1:IDX_W].
- R2: A hit (the line at the virtual index is valid and holds the same virtual tag) responds with rsp_hit=1 and rsp_kind=0. It makes no memory transaction. A write hit returns the written data.
- R3: A miss whose physical address matches a live pointer entry responds with rsp_kind=1 (synonym move). A pointer entry is live when it is valid and the line it names is valid and holds the entry's physical address. The data of the pointed line moves to the line at the virtual index, and the old line becomes invalid. The entry is freed if the access is aligned and retargeted to the new line otherwise. No memory read takes place.
- R4: A miss that is aligned and not covered by R3 responds with rsp_kind=0. If the line at the virtual index already holds the requested physical block, that data is reused under the new tag with no memory read. Otherwise one memory read fills the line.
- R5: An unaligned miss not covered by R3 checks the line at physical bits [IDX_W-1:0]. If that line is valid and holds the requested physical block, its data and dirty state serve the miss, that line is invalidated, and rsp_kind=2 (aligned-invalidate). No memory read takes place.
- R6: An unaligned miss not covered by R3 takes a pointer entry for the new line. If the entry held a live pointer to another block, that line is evicted (written back if dirty) and rsp_kind=3 (paired eviction). Code 3 takes priority over code 2. An entry whose pointer is stale causes no eviction.
- R7: A dirty line displaced from the virtual index is written back to its physical address before the new line is used. Write-backs always come before the single memory read.
- R8: A read through any virtual alias returns the last value written to that physical address through any alias.
- R9: A memory request holds mem_req, mem_we and mem_addr steady until mem_ack.
- R10: After reset there is no response and no memory request, req_ready is high, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ready | output | 1 | Block is idle and takes a request |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_va | input | VA_W | Virtual word address |
| req_pa | input | PA_W | Translated physical word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response was a hit |
| rsp_kind | output | 2 | 0 fill, 1 synonym move, 2 aligned-invalidate, 3 paired eviction |
| rsp_data | output | DATA_W | Read data, or the written data on a write |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | PA_W | Physical word address of the transaction |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory completes the current transaction |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |

## Verification
The bench builds the block with 16 lines, four-word pages, two colour bits and a pointer store of one entry. Every unaligned allocation therefore competes for the same slot, so a short sequence reaches paired evictions, stale pointers, synonym moves within one line and the write-back ordering. The physical space is 256 words, so the bench memory and its shadow of the expected contents are complete. The bench can then predict every read value and every transaction count on its own.

// File: rtl/syn_vcache_pkg.sv
package syn_vcache_pkg;

  typedef enum logic [1:0] {
    MK_FILL = 2'd0,
    MK_MOVE = 2'd1,
    MK_ALGN = 2'd2,
    MK_PAIR = 2'd3
  } miss_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBT,
    ST_WBP,
    ST_RD,
    ST_FIN
  } vc_state_e;

  // First memory step still owed, in fixed order: victim, paired line, read.
  function automatic vc_state_e next_mem_step(logic wbt, logic wbp, logic rd);
    if (wbt) return ST_WBT;
    if (wbp) return ST_WBP;
    if (rd)  return ST_RD;
    return ST_FIN;
  endfunction

  // Kind of miss handling, with paired eviction above aligned-invalidate.
  function automatic miss_kind_e classify_miss(logic syn, logic pair, logic asyn);
    if (syn)  return MK_MOVE;
    if (pair) return MK_PAIR;
    if (asyn) return MK_ALGN;
    return MK_FILL;
  endfunction

endpackage

// File: rtl/syn_vcache_align.sv
module syn_vcache_align #(
  parameter int IDX_W  = 8,
  parameter int PAGE_W = 4,
  localparam int CLR_W = IDX_W - PAGE_W
) (
  input  logic [CLR_W-1:0] va_clr,
  input  logic [IDX_W-1:0] pa_idx,
  output logic             aligned,
  output logic [IDX_W-1:0] phys_line
);
  assign aligned   = (va_clr == pa_idx[IDX_W-1:PAGE_W]);
  assign phys_line = pa_idx;
endmodule

// File: rtl/syn_vcache_ptrs.sv
module syn_vcache_ptrs #(
  parameter int PA_W  = 16,
  parameter int IDX_W = 8,
  parameter int PS_N  = 8,
  localparam int SW   = (PS_N > 1) ? $clog2(PS_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  pa,
  output logic             ent_vld,
  output logic [PA_W-1:0]  ent_pa,
  output logic [IDX_W-1:0] ent_line,
  input  logic             wr_en,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_line
);
  logic [PS_N-1:0]  vld_m;
  logic [PA_W-1:0]  pa_m   [PS_N];
  logic [IDX_W-1:0] line_m [PS_N];
  logic [SW-1:0]    slot;

  generate
    if (PS_N > 1) begin : g_multi
      assign slot = pa[SW-1:0];
    end else begin : g_single
      assign slot = '0;
    end
  endgenerate

  assign ent_vld  = vld_m[slot];
  assign ent_pa   = pa_m[slot];
  assign ent_line = line_m[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_m <= '0;
    else if (wr_en) vld_m[slot] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pa_m[slot]   <= pa;
      line_m[slot] <= wr_line;
    end
  end
endmodule

// File: rtl/syn_vcache_lines.sv
module syn_vcache_lines #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 12,
  parameter int PA_W   = 16,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx   [3],
  output logic              rd_vld   [3],
  output logic              rd_dirty [3],
  output logic [PA_W-1:0]   rd_pa    [3],
  output logic [DATA_W-1:0] rd_data  [3],
  output logic [TAG_W-1:0]  rd0_vtag,
  output logic [LINES-1:0]  vld_all,
  input  logic [LINES-1:0]  inv_mask,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_vtag,
  input  logic [PA_W-1:0]   wr_pa,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty
);
  logic [LINES-1:0]  vld;
  logic [LINES-1:0]  dirty;
  logic [TAG_W-1:0]  vtag_m [LINES];
  logic [PA_W-1:0]   pa_m   [LINES];
  logic [DATA_W-1:0] data_m [LINES];

  generate
    for (genvar p = 0; p < 3; p++) begin : g_rd
      assign rd_vld[p]   = vld[rd_idx[p]];
      assign rd_dirty[p] = dirty[rd_idx[p]];
      assign rd_pa[p]    = pa_m[rd_idx[p]];
      assign rd_data[p]  = data_m[rd_idx[p]];
    end
  endgenerate

  assign rd0_vtag = vtag_m[rd_idx[0]];
  assign vld_all  = vld;

  // Invalidations first; the install at wr_idx overrides them.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      dirty <= '0;
    end else begin
      vld <= vld & ~inv_mask;
      if (wr_en) begin
        vld[wr_idx]   <= 1'b1;
        dirty[wr_idx] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vtag_m[wr_idx] <= wr_vtag;
      pa_m[wr_idx]   <= wr_pa;
      data_m[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/syn_vcache.sv
module syn_vcache
  import syn_vcache_pkg::*;
#(
  parameter int VA_W   = 20,
  parameter int PA_W   = 16,
  parameter int IDX_W  = 8,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 32,
  parameter int PS_N   = 8,
  localparam int LINES = 1 << IDX_W,
  localparam int TAG_W = VA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_ready,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PA_W-1:0]   req_pa,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  vc_state_e st;

  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   pa_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic              hit_q, aligned_q, syn_q, asyn_q, pair_q, wbp_q, rd_q;
  miss_kind_e        kind_q;
  logic [IDX_W-1:0]  t_q, s_q, a_q;
  logic [DATA_W-1:0] src_q, vt_dat_q, vp_dat_q;
  logic              srcd_q;
  logic [PA_W-1:0]   vt_pa_q, vp_pa_q;

  // Internal events brought out for the checker.
  logic in_look, look_hit, fin;
  assign in_look = (st == ST_LOOK);
  assign fin     = (st == ST_FIN);

  // Alignment and physically derived line.
  logic             aligned_w;
  logic [IDX_W-1:0] phys_line;
  syn_vcache_align #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_align (
    .va_clr(va_q[IDX_W-1:PAGE_W]), .pa_idx(pa_q[IDX_W-1:0]),
    .aligned(aligned_w), .phys_line(phys_line)
  );

  // Pointer store.
  logic             ent_vld, ps_wr;
  logic [PA_W-1:0]  ent_pa;
  logic [IDX_W-1:0] ent_line;
  assign ps_wr = fin && !hit_q && (syn_q || !aligned_q);
  syn_vcache_ptrs #(.PA_W(PA_W), .IDX_W(IDX_W), .PS_N(PS_N)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .pa(pa_q),
    .ent_vld(ent_vld), .ent_pa(ent_pa), .ent_line(ent_line),
    .wr_en(ps_wr), .wr_vld(!aligned_q), .wr_line(t_q)
  );

  // Line array: port 0 virtual index, port 1 pointed line, port 2 physical line.
  logic [IDX_W-1:0]  rd_idx   [3];
  logic              r_vld    [3];
  logic              r_dirty  [3];
  logic [PA_W-1:0]   r_pa     [3];
  logic [DATA_W-1:0] r_data   [3];
  logic [TAG_W-1:0]  r0_vtag;
  logic [LINES-1:0]  vld_all, inv_mask;
  logic [IDX_W-1:0]  t_idx;
  logic [DATA_W-1:0] fin_data;

  assign t_idx     = va_q[IDX_W-1:0];
  assign rd_idx[0] = t_idx;
  assign rd_idx[1] = ent_line;
  assign rd_idx[2] = phys_line;
  assign fin_data  = we_q ? wd_q : src_q;

  syn_vcache_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PA_W(PA_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_vld(r_vld), .rd_dirty(r_dirty),
    .rd_pa(r_pa), .rd_data(r_data), .rd0_vtag(r0_vtag), .vld_all(vld_all),
    .inv_mask(inv_mask), .wr_en(fin), .wr_idx(t_q), .wr_vtag(va_q[VA_W-1:IDX_W]),
    .wr_pa(pa_q), .wr_data(fin_data), .wr_dirty(srcd_q | we_q)
  );

  // Miss decisions taken in the look cycle.
  logic hit_w, ent_live, syn_w, tsame_w, asyn_w, pair_w, wbt_w, wbp_w, rd_w;
  assign hit_w    = r_vld[0] && (r0_vtag == va_q[VA_W-1:IDX_W]);
  assign look_hit = in_look && hit_w;
  assign ent_live = ent_vld && r_vld[1] && (r_pa[1] == ent_pa);
  assign syn_w    = ent_live && (ent_pa == pa_q);
  assign tsame_w  = r_vld[0] && (r_pa[0] == pa_q);
  assign asyn_w   = !syn_w && !aligned_w && r_vld[2] && (r_pa[2] == pa_q);
  assign pair_w   = !syn_w && !aligned_w && ent_live;
  assign wbt_w    = r_vld[0] && r_dirty[0] && !tsame_w;
  assign wbp_w    = pair_w && r_dirty[1] && (ent_line != t_idx);
  assign rd_w     = !syn_w && !tsame_w && !asyn_w;

  always_comb begin
    inv_mask = '0;
    if (fin && !hit_q) begin
      if ((syn_q && s_q != t_q) || pair_q) inv_mask[s_q] = 1'b1;
      if (asyn_q) inv_mask[a_q] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE: if (req_valid) st <= ST_LOOK;
        ST_LOOK: st <= hit_w ? ST_FIN : next_mem_step(wbt_w, wbp_w, rd_w);
        ST_WBT:  if (mem_ack) st <= next_mem_step(1'b0, wbp_q, rd_q);
        ST_WBP:  if (mem_ack) st <= next_mem_step(1'b0, 1'b0, rd_q);
        ST_RD:   if (mem_ack) st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_IDLE && req_valid) begin
      va_q <= req_va;
      pa_q <= req_pa;
      we_q <= req_we;
      wd_q <= req_wdata;
    end
    if (in_look) begin
      hit_q     <= hit_w;
      aligned_q <= aligned_w;
      syn_q     <= !hit_w && syn_w;
      asyn_q    <= !hit_w && asyn_w;
      pair_q    <= !hit_w && pair_w;
      wbp_q     <= wbp_w;
      rd_q      <= rd_w;
      kind_q    <= hit_w ? MK_FILL : classify_miss(syn_w, pair_w, asyn_w);
      t_q       <= t_idx;
      s_q       <= ent_line;
      a_q       <= phys_line;
      vt_pa_q   <= r_pa[0];
      vt_dat_q  <= r_data[0];
      vp_pa_q   <= r_pa[1];
      vp_dat_q  <= r_data[1];
      if (hit_w || (!syn_w && tsame_w)) begin
        src_q  <= r_data[0];
        srcd_q <= r_dirty[0];
      end else if (syn_w) begin
        src_q  <= r_data[1];
        srcd_q <= r_dirty[1];
      end else if (asyn_w) begin
        src_q  <= r_data[2];
        srcd_q <= r_dirty[2];
      end
    end
    if (st == ST_RD && mem_ack) begin
      src_q  <= mem_rdata;
      srcd_q <= 1'b0;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pa_q;
    mem_wdata = vt_dat_q;
    unique case (st)
      ST_WBT: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = vt_pa_q; end
      ST_WBP: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = vp_pa_q; mem_wdata = vp_dat_q; end
      ST_RD:  mem_req = 1'b1;
      default: ;
    endcase
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = fin;
  assign rsp_hit   = hit_q;
  assign rsp_kind  = kind_q;
  assign rsp_data  = fin_data;
endmodule

// File: rtl/syn_vcache_chk.sv
module syn_vcache_chk #(
  parameter int IDX_W = 8,
  parameter int PA_W  = 16,
  localparam int LINES = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [PA_W-1:0]  mem_addr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [1:0]       rsp_kind,
  input logic             in_look,
  input logic             look_hit,
  input logic [LINES-1:0] vld_all,
  input logic [IDX_W-1:0] t_q,
  input logic [IDX_W-1:0] s_q,
  input logic [IDX_W-1:0] a_q
);
  // R2
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_look && look_hit) |=> (!mem_req && rsp_valid));

  // R2
  hit_kind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_kind == 2'd0));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3
  move_clears_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && rsp_kind == 2'd1 && s_q != t_q) |=> (!vld_all[s_q] && vld_all[t_q]));

  // R5
  algn_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && rsp_kind == 2'd2) |=> (!vld_all[a_q] && vld_all[t_q]));

  // R6
  pair_evicts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && rsp_kind == 2'd3 && s_q != t_q) |=> !vld_all[s_q]);

  // R10
  no_rsp_with_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req);
endmodule

bind syn_vcache syn_vcache_chk #(.IDX_W(IDX_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_kind(rsp_kind),
  .in_look(in_look), .look_hit(look_hit), .vld_all(vld_all),
  .t_q(t_q), .s_q(s_q), .a_q(a_q)
);

// File: tb/syn_vcache_test.sv
module syn_vcache_test;
  localparam int VA_W = 10, PA_W = 8, IDX_W = 4, PAGE_W = 2, DATA_W = 16, PS_N = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_ready, req_valid = 1'b0, req_we = 1'b0;
  logic [VA_W-1:0]   req_va = '0;
  logic [PA_W-1:0]   req_pa = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid, rsp_hit;
  logic [1:0]        rsp_kind;
  logic [DATA_W-1:0] rsp_data;
  logic              mem_req, mem_we, mem_ack;
  logic [PA_W-1:0]   mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  syn_vcache #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W),
               .DATA_W(DATA_W), .PS_N(PS_N)) uut (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_valid(req_valid),
    .req_we(req_we), .req_va(req_va), .req_pa(req_pa), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model: acknowledges one cycle after the request is seen.
  logic [DATA_W-1:0] mem_m [256];
  int   ops_cnt = 0, hold_err = 0;
  logic pend = 1'b0;
  logic [PA_W-1:0] pend_addr = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= 16'h5000 + 16'(i);
      mem_ack <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (pend && (!mem_req || mem_addr != pend_addr)) hold_err <= hold_err + 1;
      pend      <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
      mem_ack   <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem_m[mem_addr];
        if (mem_we) mem_m[mem_addr] <= mem_wdata;
      end
      if (mem_req && mem_ack) ops_cnt <= ops_cnt + 1;
    end
  end

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      $display("FAIL watchdog expired: actual %0d cycles, expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [9:0]  va;
    logic [7:0]  pa;
    logic [15:0] wd;
    logic        hit;
    logic [1:0]  kind;
    logic [1:0]  ops;
  } vec_t;

  // kind: 0 fill, 1 synonym move, 2 aligned-invalidate, 3 paired eviction
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'h010, 8'h10, 16'h0000, 1'b0, 2'd0, 2'd1},
    '{1'b0, 10'h010, 8'h10, 16'h0000, 1'b1, 2'd0, 2'd0},
    '{1'b1, 10'h010, 8'h10, 16'hA1A1, 1'b1, 2'd0, 2'd0},
    '{1'b0, 10'h024, 8'h10, 16'h0000, 1'b0, 2'd2, 2'd0},
    '{1'b0, 10'h010, 8'h10, 16'h0000, 1'b0, 2'd1, 2'd0},
    '{1'b0, 10'h024, 8'h10, 16'h0000, 1'b0, 2'd2, 2'd0},
    '{1'b1, 10'h024, 8'h10, 16'hB2B2, 1'b1, 2'd0, 2'd0},
    '{1'b0, 10'h038, 8'h21, 16'h0000, 1'b0, 2'd3, 2'd2},
    '{1'b0, 10'h010, 8'h10, 16'h0000, 1'b0, 2'd0, 2'd1},
    '{1'b0, 10'h0B8, 8'h21, 16'h0000, 1'b0, 2'd1, 2'd0},
    '{1'b1, 10'h0B8, 8'h21, 16'hC3C3, 1'b1, 2'd0, 2'd0},
    '{1'b0, 10'h038, 8'h21, 16'h0000, 1'b0, 2'd1, 2'd0},
    '{1'b0, 10'h118, 8'h68, 16'h0000, 1'b0, 2'd0, 2'd2},
    '{1'b0, 10'h038, 8'h21, 16'h0000, 1'b0, 2'd0, 2'd1},
    '{1'b0, 10'h050, 8'h10, 16'h0000, 1'b0, 2'd0, 2'd0},
    '{1'b1, 10'h064, 8'h34, 16'hD4D4, 1'b0, 2'd0, 2'd1},
    '{1'b0, 10'h064, 8'h34, 16'h0000, 1'b1, 2'd0, 2'd0}
  };

  logic [DATA_W-1:0] shadow [256];

  function automatic string kind_tag(logic [1:0] k);
    case (k)
      2'd1: return "R3 synonym-move kind";
      2'd2: return "R5 aligned-invalidate kind (R1)";
      2'd3: return "R6 paired-eviction kind (R1)";
      default: return "R4 fill kind (R1)";
    endcase
  endfunction

  task automatic run_vec(vec_t v, int n);
    int start, w;
    logic [DATA_W-1:0] exp_d;
    @(negedge clk);
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    start     = ops_cnt;
    req_valid = 1'b1;
    req_we    = v.we;
    req_va    = v.va;
    req_pa    = v.pa;
    req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!rsp_valid && w < 100) begin @(negedge clk); w++; end
    exp_d = v.we ? v.wd : shadow[v.pa];
    check($sformatf("R8 data vec %0d", n), int'(rsp_data), int'(exp_d));
    check($sformatf("R2 hit flag vec %0d", n), int'(rsp_hit), int'(v.hit));
    check($sformatf("%s vec %0d", kind_tag(v.kind), n), int'(rsp_kind), int'(v.kind));
    check($sformatf("R7 memory transactions vec %0d", n), ops_cnt - start, int'(v.ops));
    if (v.we) shadow[v.pa] = v.wd;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 16'h5000 + 16'(i);
    repeat (3) @(negedge clk);
    // R10: state held in reset
    check("R10 rsp_valid in reset", int'(rsp_valid), 0);
    check("R10 mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 req_ready after reset", int'(req_ready), 1);
    check("R10 no response after reset", int'(rsp_valid), 0);

    for (int n = 0; n < NV; n++) run_vec(VEC[n], n);

    // Directed corners: write-back of a paired-evicted line reaches memory (R6, R7)
    @(negedge clk);
    check("R6 paired victim written to memory", int'(mem_m[8'h10]), int'(16'hB2B2));
    check("R7 displaced dirty line written to memory", int'(mem_m[8'h21]), int'(16'hC3C3));
    check("R9 request hold violations", hold_err, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule